// File: doc/BRIEF.md
# I2C Master Bit Engine with Bus Recovery

This block is the bit-level half of a single-master I2C controller. A sequencer above it issues one primitive at a time: a START condition, a STOP condition, a byte write, a byte read with a chosen acknowledge level, or a bus-recovery burst. The engine turns each primitive into timed edges on SCL and on an open-drain SDA. Every edge is paced by a quarter-bit tick, which is produced by dividing the system clock by a parameter.

SDA appears as a pull-low enable and a separate input sample. The engine never drives the line high: it either pulls SDA low or releases it to the pull-up. When a primitive finishes, the engine gives a one-cycle done pulse. For a write it also returns the acknowledge level it sampled, and for a read it returns the byte it received. The recovery primitive clocks nine pulses with SDA released and then closes with a STOP. This returns a target that was left mid-byte to idle.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, scl_o is 1, sda_oe is 0, busy is 0 and done is 0.
- R2: A command is accepted when cmd_valid is high, busy is low and cmd_op is 1 (START), 2 (STOP), 3 (WRITE), 4 (READ) or 5 (RECOVER).
  - From the cycle after acceptance, busy stays high until done pulses.
  - Done is high for exactly one cycle.
  - One tick is TICK_DIV clock cycles. Done becomes visible START 4, STOP 5, WRITE 37, READ 37 and RECOVER 41 ticks after the accepting edge.
- R3: START takes SDA high and then SCL high. It then pulls SDA low while SCL is high: exactly one falling SDA edge with SCL high and no rising one. The engine ends with SCL high and SDA pulled low.
- R4: STOP takes SCL low, pulls SDA low and raises SCL. It then releases SDA while SCL is high: exactly one rising SDA edge with SCL high and no falling one. The engine ends with SCL high and SDA released.
- R5: WRITE gives nine SCL rising edges. SDA at the first eight rises equals cmd_wdata, most significant bit first. SDA is released for the ninth clock. SDA never changes while SCL is high.
- R6: After a WRITE, ack_o holds the SDA level sampled during the ninth clock: 0 means acknowledge, 1 means not-acknowledge.
- R7: READ releases SDA for eight clocks and gives nine SCL rising edges. rdata holds the eight levels sampled while SCL was high, most significant bit first. On the ninth clock the engine shows cmd_ack_lvl on SDA: 0 pulls the line low, 1 leaves it released.
- R8: In WRITE, READ and RECOVER, every SCL high phase that ends in a fall lasts exactly two ticks (2*TICK_DIV cycles).
- R9: RECOVER gives nine SCL clocks with SDA released, followed by a STOP. That is ten SCL rises, one rising SDA edge with SCL high and no falling one. The engine ends with both lines released.
- R10: cmd_valid is ignored while busy is high. It is also ignored for cmd_op values 0, 6 and 7. An ignored command does not change busy, the line levels or the result of the primitive in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Primitive code: 1 START, 2 STOP, 3 WRITE, 4 READ, 5 RECOVER |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_ack_lvl | input | 1 | Acknowledge level to send after READ (0 ACK, 1 NACK) |
| busy | output | 1 | A primitive is in progress |
| done | output | 1 | One-cycle pulse when a primitive completes |
| rdata | output | 8 | Byte received by the last READ |
| ack_o | output | 1 | Acknowledge level sampled by the last WRITE |
| scl_o | output | 1 | SCL level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Some properties are checked by the assertions on every cycle:
- SDA stays stable while SCL is high inside byte clocks.
- Done pulses for one cycle only and never together with busy.
- Accepted primitives hold their opcode.
- The step counter stays in range.
- Ticks are spaced apart.
- Each primitive finishes with the line levels it must leave behind.

Other behaviour can only be shown by the bench's scenarios:
- bit order, and sampling of the target's data and acknowledge;
- exact done latency;
- the two-tick high phase;
- the count of clocks and STOP conditions in recovery;
- that commands issued while busy or with an unknown opcode leave a transfer untouched.

The bench shows these by observing the bus through a modelled open-drain target, sweeping all 256 byte values for both writes and reads.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam int BYTE_W     = 8;
  localparam int SLOT_TICKS = 4;
  localparam int BYTE_SLOTS = BYTE_W + 1;
  localparam int BYTE_STEPS = BYTE_SLOTS * SLOT_TICKS;
  localparam int STOP_STEPS = 5;
  localparam int MAX_STEP   = BYTE_STEPS + STOP_STEPS - 1;
  localparam int STEP_W     = $clog2(MAX_STEP + 1);

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_RECOVER = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    SDA_KEEP, SDA_RELEASE, SDA_PULL, SDA_TXBIT, SDA_ACKBIT
  } sda_act_e;

  typedef struct packed {
    logic     scl_set;
    logic     scl_val;
    sda_act_e sda;
    logic     shift_tx;
    logic     sample_rx;
    logic     sample_ack;
    logic     last;
  } step_act_t;

  function automatic logic op_is_valid(logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic int last_step(op_e op);
    case (op)
      OP_START:          return 3;
      OP_STOP:           return STOP_STEPS - 1;
      OP_WRITE, OP_READ: return BYTE_STEPS;
      OP_RECOVER:        return MAX_STEP;
      default:           return 0;
    endcase
  endfunction

  function automatic step_act_t stop_seq(int k);
    step_act_t a;
    a = '0;
    a.sda = SDA_KEEP;
    case (k)
      0:       begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
      1:       a.sda = SDA_PULL;
      2:       begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
      3:       a.sda = SDA_RELEASE;
      default: a.last = 1'b1;
    endcase
    return a;
  endfunction

  function automatic step_act_t decode_step(op_e op, logic [STEP_W-1:0] step);
    step_act_t a;
    int s;
    int slot;
    int sub;
    a    = '0;
    a.sda = SDA_KEEP;
    s    = int'(step);
    slot = s / SLOT_TICKS;
    sub  = s % SLOT_TICKS;
    case (op)
      OP_START: begin
        case (s)
          0:       a.sda = SDA_RELEASE;
          1:       begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
          2:       a.sda = SDA_PULL;
          default: a.last = 1'b1;
        endcase
      end
      OP_STOP: a = stop_seq(s);
      OP_WRITE, OP_READ, OP_RECOVER: begin
        if (s < BYTE_STEPS) begin
          case (sub)
            0: begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
            1: begin
              if (op == OP_WRITE && slot < BYTE_W) begin
                a.sda = SDA_TXBIT;
                a.shift_tx = 1'b1;
              end else if (op == OP_READ && slot == BYTE_W) begin
                a.sda = SDA_ACKBIT;
              end else begin
                a.sda = SDA_RELEASE;
              end
            end
            2: begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
            default: begin
              a.sample_rx  = (op == OP_READ)  && (slot < BYTE_W);
              a.sample_ack = (op == OP_WRITE) && (slot == BYTE_W);
            end
          endcase
        end else if (op == OP_RECOVER) begin
          a = stop_seq(s - BYTE_STEPS);
        end else begin
          a.scl_set = 1'b1;
          a.scl_val = 1'b0;
          a.last    = 1'b1;
        end
      end
      default: a.last = 1'b1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= RELOAD;
    else if (restart)           cnt_q <= RELOAD;
    else if (run) begin
      if (cnt_q == '0)          cnt_q <= RELOAD;
      else                      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tick = run && !restart && (cnt_q == '0);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R8
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2c_step_decode.sv
module i2c_step_decode
  import i2c_bit_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output step_act_t         act
);
  always_comb act = decode_step(op, step);
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
  import i2c_bit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              shift_tx,
  input  logic              sample_rx,
  input  logic              sample_ack,
  input  logic              sda_in,
  output logic              tx_msb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_lvl
);
  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_byte <= '0;
      ack_lvl <= 1'b1;
    end else begin
      if (load)            tx_q <= wdata;
      else if (shift_tx)   tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      if (sample_rx)       rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
      if (sample_ack)      ack_lvl <= sda_in;
    end
  end

  assign tx_msb = tx_q[BYTE_W-1];
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [7:0]  cmd_wdata,
  input  logic        cmd_ack_lvl,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        ack_o,
  output logic        scl_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  logic              busy_q, done_q, scl_q, sda_oe_q, ack_req_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic              accept, tick, tx_msb;
  step_act_t         act;
  logic              step_fire;

  assign accept    = cmd_valid && !busy_q && op_is_valid(cmd_op);
  assign step_fire = busy_q && tick;

  i2c_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy_q), .tick(tick)
  );

  i2c_step_decode u_dec (.op(op_q), .step(step_q), .act(act));

  i2c_byte_shift u_data (
    .clk(clk), .rst_n(rst_n), .load(accept), .wdata(cmd_wdata),
    .shift_tx(step_fire && act.shift_tx),
    .sample_rx(step_fire && act.sample_rx),
    .sample_ack(step_fire && act.sample_ack),
    .sda_in(sda_i), .tx_msb(tx_msb), .rx_byte(rdata), .ack_lvl(ack_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      scl_q     <= 1'b1;
      sda_oe_q  <= 1'b0;
      ack_req_q <= 1'b1;
      op_q      <= OP_NONE;
      step_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        op_q      <= op_e'(cmd_op);
        step_q    <= '0;
        ack_req_q <= cmd_ack_lvl;
      end else if (step_fire) begin
        if (act.scl_set) scl_q <= act.scl_val;
        case (act.sda)
          SDA_RELEASE: sda_oe_q <= 1'b0;
          SDA_PULL:    sda_oe_q <= 1'b1;
          SDA_TXBIT:   sda_oe_q <= !tx_msb;
          SDA_ACKBIT:  sda_oe_q <= !ack_req_q;
          default:     sda_oe_q <= sda_oe_q;
        endcase
        step_q <= step_q + STEP_W'(1);
        if (act.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign scl_o  = scl_q;
  assign sda_oe = sda_oe_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q ##1 !done_q));
  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(step_q) <= last_step(op_q)));
  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(step_fire && act.last)) |=> (busy_q && $stable(op_q)));
  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cmd_valid && !op_is_valid(cmd_op)) |=> !busy_q);
  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (op_q == OP_WRITE || op_q == OP_READ) && scl_q && $past(scl_q))
      |-> $stable(sda_oe_q));
  // R3
  start_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_START) |-> (scl_q && sda_oe_q));
  // R4
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (op_q == OP_STOP || op_q == OP_RECOVER)) |-> (scl_q && !sda_oe_q));

endmodule

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic cmd_ack_lvl = 1'b0;
  logic busy, done, ack_o, scl, sda_oe;
  logic [7:0] rdata;
  logic tgt_low = 1'b0;
  wire  sda_line = !(sda_oe || tgt_low);

  int checks = 0;
  int errors = 0;

  logic mon_clr = 1'b0;
  logic [8:0] pat = 9'h1FF;
  int rises = 0, starts = 0, stops = 0, hcnt = 0, hmin = 1000, hmax = 0;
  logic [8:0] obs = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bit_engine #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl), .busy(busy), .done(done),
    .rdata(rdata), .ack_o(ack_o), .scl_o(scl), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  always @(posedge clk) begin
    if (mon_clr) begin
      rises <= 0; obs <= '0; starts <= 0; stops <= 0;
      hcnt <= 0; hmin <= 1000; hmax <= 0;
      tgt_low <= 1'b0;
    end else begin
      if (scl && !p_scl) begin
        rises <= rises + 1;
        obs <= {obs[7:0], sda_line};
      end
      if (scl && p_scl && (sda_line != p_sda)) begin
        if (!sda_line) starts <= starts + 1;
        else           stops  <= stops + 1;
      end
      if (scl) hcnt <= hcnt + 1;
      if (!scl && p_scl) begin
        if (hcnt < hmin) hmin <= hcnt;
        if (hcnt > hmax) hmax <= hcnt;
        hcnt <= 0;
      end
      if (!scl) tgt_low <= (rises < 9) ? !pat[8 - rises] : 1'b0;
    end
    p_scl <= scl;
    p_sda <= sda_line;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  int lat;

  task automatic run_op(input logic [2:0] op, input logic [7:0] wd,
                        input logic al, input logic [8:0] tp, input bit intrude);
    pat = tp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = al; mon_clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; mon_clr = 1'b0;
    check("R2 busy after accept", int'(busy), 1);
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 10) begin
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_wdata = ~wd; cmd_ack_lvl = ~al;
      end
      if (intrude && lat == 11) cmd_valid = 1'b0;
    end
    check("R2 busy low at done", int'(busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl", int'(scl), 1);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 recovery from idle
    run_op(3'd5, 8'h00, 1'b0, 9'h1FF, 1'b0);
    check("R2 recover latency", lat, 41*DIV);
    check("R9 rises", rises, 10);
    check("R9 stops", stops, 1);
    check("R9 starts", starts, 0);
    check("R9 scl end", int'(scl), 1);
    check("R9 sda end", int'(sda_line), 1);
    @(negedge clk);
    check("R2 done single", int'(done), 0);

    // R3 start
    run_op(3'd1, 8'h00, 1'b0, 9'h1FF, 1'b0);
    check("R2 start latency", lat, 4*DIV);
    check("R3 starts", starts, 1);
    check("R3 stops", stops, 0);
    check("R3 scl end", int'(scl), 1);
    check("R3 sda end", int'(sda_line), 0);

    // R5 R6 R8 write sweep
    for (int i = 0; i < 256; i++) begin
      logic at;
      at = i[0];
      run_op(3'd3, 8'(i), 1'b0, {8'hFF, at}, 1'b0);
      check("R2 write latency", lat, 37*DIV);
      check("R5 bits", int'(obs), int'({8'(i), at}));
      check("R5 rises", rises, 9);
      check("R5 no start/stop", starts + stops, 0);
      check("R6 ack", int'(ack_o), int'(at));
      if (i > 0) begin
        check("R8 write high min", hmin, 2*DIV);
        check("R8 write high max", hmax, 2*DIV);
      end
    end

    // R10 command during busy ignored
    run_op(3'd3, 8'hA5, 1'b1, 9'h1FE, 1'b1);
    check("R10 latency", lat, 37*DIV);
    check("R10 bits", int'(obs), int'(9'h14A));
    check("R10 ack", int'(ack_o), 0);
    @(negedge clk);
    check("R10 no restart", int'(busy), 0);

    // R7 R8 read sweep
    for (int i = 0; i < 256; i++) begin
      logic al;
      al = i[1];
      run_op(3'd4, 8'h00, al, {8'(i), 1'b1}, 1'b0);
      check("R2 read latency", lat, 37*DIV);
      check("R7 rdata", int'(rdata), i);
      check("R7 bus bits", int'(obs), int'({8'(i), al}));
      check("R7 no start/stop", starts + stops, 0);
      check("R8 read high min", hmin, 2*DIV);
      check("R8 read high max", hmax, 2*DIV);
    end

    // R8 R9 recovery after byte clocks
    run_op(3'd5, 8'h00, 1'b0, 9'h1FF, 1'b0);
    check("R9 rises after read", rises, 10);
    check("R9 stops after read", stops, 1);
    check("R9 starts after read", starts, 0);
    check("R8 recover high min", hmin, 2*DIV);
    check("R8 recover high max", hmax, 2*DIV);

    // R4 stop after start
    run_op(3'd1, 8'h00, 1'b0, 9'h1FF, 1'b0);
    run_op(3'd2, 8'h00, 1'b0, 9'h1FF, 1'b0);
    check("R2 stop latency", lat, 5*DIV);
    check("R4 stops", stops, 1);
    check("R4 starts", starts, 0);
    check("R4 scl end", int'(scl), 1);
    check("R4 sda end", int'(sda_oe), 0);

    // R10 invalid opcodes ignored
    foreach (pat[k]) begin end
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10 bad op busy", int'(busy), 0);
      repeat (4*DIV) @(negedge clk);
      check("R10 bad op done", int'(done), 0);
      check("R10 bad op scl", int'(scl), 1);
      check("R10 bad op sda", int'(sda_oe), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule